// File: doc/BRIEF.md
# Three-Phase Common-Mode Allocation Solver

This block solves, once per control cycle, the linear allocation problem that spreads three residual phase-voltage targets over the deviation variables of a cascaded multilevel converter with N modules per phase. Every module owns two deviation variables. The positive one may move between zero and its upper limit. The negative one may move between its lower limit and zero. An upstream sorter presents each phase's 2N variables as slots, ordered from highest benefit to lowest. Each slot carries its benefit, its bounds, the module it belongs to and its polarity.

After `start`, the solver first fills each phase greedily. All slots begin at their lower bounds. The remaining target is then handed out slot by slot in benefit order, and the first slot that cannot take its full span becomes the phase's basic variable. A pivot loop follows. While the benefits of the three basic variables sum to a non-zero value, all three basic variables move by the same step in the direction of that sign. Each step ends when the first of them reaches a bound, and a basic variable that saturates hands over to its neighbour in benefit order. Because every step shifts all three phases by the same amount, the phase-to-phase relations of the targets are kept.

When the loop stops, the per-module deviations are presented on the outputs and a one-cycle `done` is raised. The outputs then hold until the next `start`.

Top module: `cm_alloc_solver`

## Requirements
- R1: Every slot value stays within its own bounds, written as slot_lo ≤ value ≤ slot_hi in two's complement. A positive variable has slot_lo = 0, and a negative variable has slot_hi = 0.
- R2: Slot i of phase k sits at flat index k*2N+i, and slot 0 carries the highest benefit. slot_mod gives the module index within the phase. slot_neg = 1 marks the negative variable. The module's results appear at dev_pos / dev_neg index k*N+m.
- R3: The greedy fill starts every slot at its lower bound and visits the slots in index order. A slot whose span fits in the remaining target is set to its upper bound. The first slot whose span exceeds the remainder takes lower bound plus remainder and becomes basic. If no slot qualifies, the last slot is basic. The fill takes 2N cycles.
- R4: At the end of the run, the difference between the summed deviations of phase k and phase k+1 equals ph_target[k] − ph_target[k+1], for k = 0 and k = 1.
- R5: If the first sum of basic benefits is positive, every step raises the three basic values by the smallest of their headrooms to the upper bound. Each phase whose headroom equals that step moves its basic pointer to the next slot.
- R6: If the first sum is negative, the loop mirrors R5. It uses the headrooms down to the lower bounds and moves the pointer to the previous slot.
- R7: The loop stops without stepping in the cycle where the basic-benefit sum is zero or has the opposite sign to the first sum.
- R8: The loop stops after a step that saturates the last slot of a phase (when raising) or slot 0 (when lowering). At that point all variables of that phase are saturated in one direction.
- R9: busy rises in the cycle after start is sampled and stays high for 2N + E cycles, where E is the number of loop evaluations (E ≤ 6N−3). done is then high for exactly one cycle while busy is low. After reset, busy, done and err are low and all outputs are zero.
- R10: err stays low for feasible inputs. The deviations and err keep their values from the done cycle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a solve; sampled while idle |
| slot_bnf | input | 3*2N*BW | Signed benefit per slot, sorted descending per phase |
| slot_lo | input | 3*2N*VW | Signed lower bound per slot |
| slot_hi | input | 3*2N*VW | Signed upper bound per slot |
| slot_mod | input | 3*2N*MW | Module index of each slot |
| slot_neg | input | 3*2N | 1 for a negative deviation variable |
| ph_target | input | 3*VW | Signed residual target per phase |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Iteration budget hit without termination |
| dev_pos | output | 3*N*VW | Positive deviation per module |
| dev_neg | output | 3*N*VW | Negative deviation per module |

## Verification
The hardest condition to reach from the ports is the R8 exit. Here a phase runs out of slots during a common-mode step, often in the same step in which another phase saturates. Random benefits rarely keep one sign long enough to get there. The stimulus therefore includes directed cases in which every benefit has the same sign and one phase has very narrow spans, so the loop must pivot through all of that phase's slots. A reference model in the bench predicts the exit reason, the evaluation count and every deviation. The bench compares busy and done with the model on every clock, then checks the final values and the phase-to-phase sums.

// File: rtl/alloc_pkg.sv
// Shared types for the three-phase allocation solver.
package alloc_pkg;
    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_PIVOT = 2'd2
    } solve_state_t;
endpackage

// File: rtl/alloc_phase_lane.sv
// One phase of the solver. Latches the sorted slots at load, performs the
// greedy fill one slot per cycle, then applies common-mode steps to the
// basic slot on request. Assumes the target is reachable within the
// phase's bounds and that lo <= 0 <= hi for every slot.
module alloc_phase_lane #(
    parameter int N  = 2,
    parameter int VW = 16,
    parameter int BW = 16,
    parameter int MW = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic                             walk_en,
    input  logic [$clog2(2*N)-1:0]           walk_idx,
    input  logic                             shift_en,
    input  logic                             shift_up,
    input  logic signed [VW-1:0]             step,
    input  logic [2*N-1:0][BW-1:0]           in_bnf,
    input  logic [2*N-1:0][VW-1:0]           in_lo,
    input  logic [2*N-1:0][VW-1:0]           in_hi,
    input  logic [2*N-1:0][MW-1:0]           in_mod,
    input  logic [2*N-1:0]                   in_neg,
    input  logic [VW-1:0]                    target,
    output logic signed [BW-1:0]             basic_bnf,
    output logic signed [VW-1:0]             head_up,
    output logic signed [VW-1:0]             head_dn,
    output logic                             at_top,
    output logic                             at_bot,
    output logic [N-1:0][VW-1:0]             mod_pos,
    output logic [N-1:0][VW-1:0]             mod_neg
);
    localparam int SLOTS = 2 * N;
    localparam int PW    = $clog2(SLOTS);
    localparam int RW    = VW + PW + 1;

    logic signed [VW-1:0] val_q [SLOTS];
    logic signed [VW-1:0] lo_q  [SLOTS];
    logic signed [VW-1:0] hi_q  [SLOTS];
    logic signed [BW-1:0] bnf_q [SLOTS];
    logic [MW-1:0]        mod_q [SLOTS];
    logic                 neg_q [SLOTS];
    logic [PW-1:0]        ptr_q;
    logic                 found_q;
    logic signed [RW-1:0] rem_q;
    logic signed [RW-1:0] lo_sum;
    logic signed [RW-1:0] span_w;

    // Sum of the incoming lower bounds, used to seed the remainder.
    always_comb begin
        lo_sum = '0;
        for (int i = 0; i < SLOTS; i++) begin
            lo_sum = lo_sum + RW'($signed(in_lo[i]));
        end
    end

    // Span of the slot visited by the fill this cycle.
    assign span_w = RW'(hi_q[walk_idx]) - RW'(lo_q[walk_idx]);

    // Values the controller needs from the basic slot.
    assign basic_bnf = bnf_q[ptr_q];
    assign head_up   = hi_q[ptr_q] - val_q[ptr_q];
    assign head_dn   = val_q[ptr_q] - lo_q[ptr_q];
    assign at_top    = (ptr_q == PW'(SLOTS - 1));
    assign at_bot    = (ptr_q == '0);

    // Slot storage: load, greedy fill, then common-mode steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                val_q[i] <= '0;
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                bnf_q[i] <= '0;
                mod_q[i] <= '0;
                neg_q[i] <= 1'b0;
            end
            ptr_q   <= '0;
            found_q <= 1'b0;
            rem_q   <= '0;
        end else if (load) begin
            for (int i = 0; i < SLOTS; i++) begin
                val_q[i] <= $signed(in_lo[i]);
                lo_q[i]  <= $signed(in_lo[i]);
                hi_q[i]  <= $signed(in_hi[i]);
                bnf_q[i] <= $signed(in_bnf[i]);
                mod_q[i] <= in_mod[i];
                neg_q[i] <= in_neg[i];
            end
            rem_q   <= RW'($signed(target)) - lo_sum;
            ptr_q   <= '0;
            found_q <= 1'b0;
        end else if (walk_en && !found_q) begin
            if (rem_q < span_w) begin
                val_q[walk_idx] <= lo_q[walk_idx] + VW'(rem_q);
                found_q         <= 1'b1;
            end else begin
                val_q[walk_idx] <= hi_q[walk_idx];
                rem_q           <= rem_q - span_w;
            end
            ptr_q <= walk_idx;
        end else if (shift_en) begin
            if (shift_up) begin
                val_q[ptr_q] <= val_q[ptr_q] + step;
                if (head_up == step && !at_top) ptr_q <= ptr_q + PW'(1);
            end else begin
                val_q[ptr_q] <= val_q[ptr_q] - step;
                if (head_dn == step && !at_bot) ptr_q <= ptr_q - PW'(1);
            end
        end
    end

    // Route each slot value to its module's positive or negative output.
    always_comb begin
        for (int m = 0; m < N; m++) begin
            mod_pos[m] = '0;
            mod_neg[m] = '0;
            for (int i = 0; i < SLOTS; i++) begin
                if (mod_q[i] == MW'(m)) begin
                    if (neg_q[i]) mod_neg[m] = val_q[i];
                    else          mod_pos[m] = val_q[i];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_bound_chk
            assert_slot_bounds_R1: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> (val_q[g] >= lo_q[g] && val_q[g] <= hi_q[g]));
        end
    endgenerate

    assert_ptr_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_up) |=> (ptr_q >= $past(ptr_q)));

    assert_ptr_backward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !shift_up) |=> (ptr_q <= $past(ptr_q)));
endmodule

// File: rtl/alloc_pivot_ctrl.sv
// Sequencer for the solver. Runs the 2N-cycle fill, then evaluates the
// basic-benefit sum once per cycle, chooses the step as the smallest
// headroom in the chosen direction, and stops on zero sum, sign change,
// a phase running out of slots, or the iteration budget.
module alloc_pivot_ctrl
    import alloc_pkg::*;
#(
    parameter int N   = 2,
    parameter int VW  = 16,
    parameter int BW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [2:0][BW-1:0]            bb,
    input  logic [2:0][VW-1:0]            hu,
    input  logic [2:0][VW-1:0]            hd,
    input  logic [2:0]                    at_top,
    input  logic [2:0]                    at_bot,
    output logic                          load,
    output logic                          walk_en,
    output logic [$clog2(2*N)-1:0]        walk_idx,
    output logic                          shift_en,
    output logic                          shift_up,
    output logic signed [VW-1:0]          step,
    output logic                          busy,
    output logic                          done,
    output logic                          err
);
    localparam int NPH     = 3;
    localparam int SLOTS   = 2 * N;
    localparam int PW      = $clog2(SLOTS);
    localparam int SW      = BW + 2;
    localparam int MAXIT   = 6 * N - 3;
    localparam int CW      = $clog2(MAXIT + 1);
    localparam int LAT_MAX = SLOTS + MAXIT + 1;
    localparam int LW      = $clog2(LAT_MAX + 2);

    solve_state_t         state_q;
    logic [PW-1:0]        widx_q;
    logic                 first_q;
    logic                 dir_q;
    logic [CW-1:0]        cnt_q;
    logic                 done_q;
    logic                 err_q;
    logic signed [SW-1:0] bsum;
    logic                 sum_pos;
    logic                 stop_sign;
    logic                 up_now;
    logic                 end_hit;
    logic                 pivoting;
    logic signed [VW-1:0] hsel [NPH];
    logic [LW-1:0]        lat_q;

    // Sum of the three basic benefits.
    always_comb begin
        bsum = '0;
        for (int k = 0; k < NPH; k++) begin
            bsum = bsum + SW'($signed(bb[k]));
        end
    end

    assign pivoting  = (state_q == ST_PIVOT);
    assign sum_pos   = (bsum > 0);
    assign stop_sign = (bsum == 0) || (!first_q && (sum_pos != dir_q));
    assign up_now    = first_q ? sum_pos : dir_q;

    // Headroom selection, smallest step and end-of-phase detection.
    always_comb begin
        for (int k = 0; k < NPH; k++) begin
            hsel[k] = up_now ? $signed(hu[k]) : $signed(hd[k]);
        end
        step = hsel[0];
        for (int k = 1; k < NPH; k++) begin
            if (hsel[k] < step) step = hsel[k];
        end
        end_hit = 1'b0;
        for (int k = 0; k < NPH; k++) begin
            if (hsel[k] == step && (up_now ? at_top[k] : at_bot[k])) end_hit = 1'b1;
        end
    end

    assign load     = (state_q == ST_IDLE) && start;
    assign walk_en  = (state_q == ST_WALK);
    assign walk_idx = widx_q;
    assign shift_en = pivoting && !stop_sign && (cnt_q != CW'(MAXIT));
    assign shift_up = up_now;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;

    // Sequencing of fill, pivot loop and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            first_q <= 1'b1;
            dir_q   <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WALK;
                        widx_q  <= '0;
                        first_q <= 1'b1;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_WALK: begin
                    widx_q <= widx_q + PW'(1);
                    if (widx_q == PW'(SLOTS - 1)) state_q <= ST_PIVOT;
                end
                ST_PIVOT: begin
                    if (stop_sign) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (cnt_q == CW'(MAXIT)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                    end else begin
                        first_q <= 1'b0;
                        dir_q   <= up_now;
                        cnt_q   <= cnt_q + CW'(1);
                        if (end_hit) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Busy-cycle counter that supports the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (load)   lat_q <= '0;
        else if (busy)   lat_q <= lat_q + LW'(1);
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_q <= LW'(LAT_MAX)));

    assert_raise_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_up) |-> (bsum > 0));

    assert_lower_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !shift_up) |-> (bsum < 0));

    assert_zero_sum_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pivoting && bsum == 0) |=> (done && !busy));
endmodule

// File: rtl/cm_alloc_solver.sv
// Top of the three-phase allocation solver: three phase lanes sharing one
// pivot controller. The lanes expose their basic slot's benefit and
// headrooms; the controller returns a common step for all three.
module cm_alloc_solver #(
    parameter int N  = 2,
    parameter int VW = 16,
    parameter int BW = 16,
    parameter int MW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [3*2*N-1:0][BW-1:0]     slot_bnf,
    input  logic [3*2*N-1:0][VW-1:0]     slot_lo,
    input  logic [3*2*N-1:0][VW-1:0]     slot_hi,
    input  logic [3*2*N-1:0][MW-1:0]     slot_mod,
    input  logic [3*2*N-1:0]             slot_neg,
    input  logic [2:0][VW-1:0]           ph_target,
    output logic                         busy,
    output logic                         done,
    output logic                         err,
    output logic [3*N-1:0][VW-1:0]       dev_pos,
    output logic [3*N-1:0][VW-1:0]       dev_neg
);
    localparam int NPH   = 3;
    localparam int SLOTS = 2 * N;
    localparam int PW    = $clog2(SLOTS);

    logic                   load_w;
    logic                   walk_en_w;
    logic [PW-1:0]          walk_idx_w;
    logic                   shift_en_w;
    logic                   shift_up_w;
    logic signed [VW-1:0]   step_w;
    logic [NPH-1:0][BW-1:0] bb_w;
    logic [NPH-1:0][VW-1:0] hu_w;
    logic [NPH-1:0][VW-1:0] hd_w;
    logic [NPH-1:0]         top_w;
    logic [NPH-1:0]         bot_w;

    generate
        for (genvar k = 0; k < NPH; k++) begin : g_lane
            alloc_phase_lane #(.N(N), .VW(VW), .BW(BW), .MW(MW)) lane_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load_w),
                .walk_en   (walk_en_w),
                .walk_idx  (walk_idx_w),
                .shift_en  (shift_en_w),
                .shift_up  (shift_up_w),
                .step      (step_w),
                .in_bnf    (slot_bnf[k*SLOTS +: SLOTS]),
                .in_lo     (slot_lo[k*SLOTS +: SLOTS]),
                .in_hi     (slot_hi[k*SLOTS +: SLOTS]),
                .in_mod    (slot_mod[k*SLOTS +: SLOTS]),
                .in_neg    (slot_neg[k*SLOTS +: SLOTS]),
                .target    (ph_target[k]),
                .basic_bnf (bb_w[k]),
                .head_up   (hu_w[k]),
                .head_dn   (hd_w[k]),
                .at_top    (top_w[k]),
                .at_bot    (bot_w[k]),
                .mod_pos   (dev_pos[k*N +: N]),
                .mod_neg   (dev_neg[k*N +: N])
            );
        end
    endgenerate

    alloc_pivot_ctrl #(.N(N), .VW(VW), .BW(BW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bb       (bb_w),
        .hu       (hu_w),
        .hd       (hd_w),
        .at_top   (top_w),
        .at_bot   (bot_w),
        .load     (load_w),
        .walk_en  (walk_en_w),
        .walk_idx (walk_idx_w),
        .shift_en (shift_en_w),
        .shift_up (shift_up_w),
        .step     (step_w),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: tb/cm_alloc_solver_tb_top.sv
// Self-checking bench with a behavioural reference model of the solver.
module cm_alloc_solver_tb_top;
    localparam int NB = 2;
    localparam int SL = 2 * NB;
    localparam int VW = 16;
    localparam int BW = 16;
    localparam int MW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3*SL-1:0][BW-1:0] slot_bnf = '0;
    logic [3*SL-1:0][VW-1:0] slot_lo = '0;
    logic [3*SL-1:0][VW-1:0] slot_hi = '0;
    logic [3*SL-1:0][MW-1:0] slot_mod = '0;
    logic [3*SL-1:0]         slot_neg = '0;
    logic [2:0][VW-1:0]      ph_target = '0;
    logic busy, done, err;
    logic [3*NB-1:0][VW-1:0] dev_pos, dev_neg;

    always #4 clk = ~clk;

    cm_alloc_solver #(.N(NB), .VW(VW), .BW(BW), .MW(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .slot_bnf(slot_bnf), .slot_lo(slot_lo), .slot_hi(slot_hi),
        .slot_mod(slot_mod), .slot_neg(slot_neg), .ph_target(ph_target),
        .busy(busy), .done(done), .err(err),
        .dev_pos(dev_pos), .dev_neg(dev_neg)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int bn[3][SL], lo_v[3][SL], hi_v[3][SL], tm[3][SL], tn[3][SL];
    int tgt[3], amax[3][NB], bmin[3][NB];
    int e_pos[3][NB], e_neg[3][NB];
    int e_eval, e_reason, e_dir;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R9: watchdog expired actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // Build one case. kind 0 random, 1 all benefits zero,
    // 2 all benefits high positive with a narrow phase 0, 3 all negative.
    task automatic make_case(input int kind);
        int eb[SL], el[SL], eh[SL], em[SL], en[SL];
        for (int k = 0; k < 3; k++) begin
            for (int m = 0; m < NB; m++) begin
                int v, u, bv, gp;
                v = 100 + int'($urandom % 200);
                u = int'($urandom % 101) - 50;
                if (kind == 2 && k == 0) begin v = 20 + int'($urandom % 10); u = 0; end
                bv = int'($urandom % 401) - 200;
                gp = int'($urandom % 50);
                if (kind == 1) begin bv = 0; gp = 0; end
                if (kind == 2) bv = 500 + int'($urandom % 100);
                if (kind == 3) bv = -500 - int'($urandom % 100);
                amax[k][m] = v - u;
                bmin[k][m] = -(v + u);
                eb[2*m] = bv - gp; el[2*m] = 0;          eh[2*m] = v - u; em[2*m] = m; en[2*m] = 0;
                eb[2*m+1] = bv + gp; el[2*m+1] = -(v + u); eh[2*m+1] = 0; em[2*m+1] = m; en[2*m+1] = 1;
            end
            for (int i = 1; i < SL; i++) begin
                for (int j = i; j > 0; j--) begin
                    if (eb[j] > eb[j-1]) begin
                        int t;
                        t = eb[j]; eb[j] = eb[j-1]; eb[j-1] = t;
                        t = el[j]; el[j] = el[j-1]; el[j-1] = t;
                        t = eh[j]; eh[j] = eh[j-1]; eh[j-1] = t;
                        t = em[j]; em[j] = em[j-1]; em[j-1] = t;
                        t = en[j]; en[j] = en[j-1]; en[j-1] = t;
                    end
                end
            end
            tgt[k] = 0;
            for (int i = 0; i < SL; i++) begin
                bn[k][i] = eb[i]; lo_v[k][i] = el[i]; hi_v[k][i] = eh[i];
                tm[k][i] = em[i]; tn[k][i] = en[i];
                tgt[k] += el[i] + int'($urandom % (eh[i] - el[i] + 1));
            end
        end
    endtask

    // Reference model: greedy fill and common-mode pivot loop, from R3 to R8.
    task automatic run_model();
        int val[3][SL];
        int ptr[3];
        int first, it, s, up, stp, endh;
        for (int k = 0; k < 3; k++) begin
            int rem, fnd;
            rem = tgt[k];
            for (int i = 0; i < SL; i++) begin val[k][i] = lo_v[k][i]; rem -= lo_v[k][i]; end
            fnd = 0; ptr[k] = 0;
            for (int i = 0; i < SL; i++) begin
                if (!fnd) begin
                    if (rem < hi_v[k][i] - lo_v[k][i]) begin
                        val[k][i] = lo_v[k][i] + rem; fnd = 1;
                    end else begin
                        val[k][i] = hi_v[k][i]; rem -= hi_v[k][i] - lo_v[k][i];
                    end
                    ptr[k] = i;
                end
            end
        end
        e_eval = 0; first = 1; e_dir = 0; it = 0; e_reason = 7;
        while (it <= 6 * NB) begin
            int hd[3];
            s = bn[0][ptr[0]] + bn[1][ptr[1]] + bn[2][ptr[2]];
            e_eval++;
            if (s == 0 || (!first && ((s > 0) != e_dir))) begin e_reason = 7; break; end
            up = first ? (s > 0) : e_dir;
            if (first) e_dir = up;
            for (int k = 0; k < 3; k++)
                hd[k] = up ? hi_v[k][ptr[k]] - val[k][ptr[k]] : val[k][ptr[k]] - lo_v[k][ptr[k]];
            stp = hd[0];
            for (int k = 1; k < 3; k++) if (hd[k] < stp) stp = hd[k];
            endh = 0;
            for (int k = 0; k < 3; k++) begin
                if (up) begin
                    val[k][ptr[k]] += stp;
                    if (hd[k] == stp) begin
                        if (ptr[k] == SL - 1) endh = 1; else ptr[k]++;
                    end
                end else begin
                    val[k][ptr[k]] -= stp;
                    if (hd[k] == stp) begin
                        if (ptr[k] == 0) endh = 1; else ptr[k]--;
                    end
                end
            end
            first = 0; it++;
            if (endh) begin e_reason = 8; break; end
        end
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < SL; i++)
                if (tn[k][i] != 0) e_neg[k][tm[k][i]] = val[k][i];
                else               e_pos[k][tm[k][i]] = val[k][i];
    endtask

    task automatic drive_case();
        for (int k = 0; k < 3; k++) begin
            ph_target[k] = VW'(tgt[k]);
            for (int i = 0; i < SL; i++) begin
                slot_bnf[k*SL+i] = BW'(bn[k][i]);
                slot_lo[k*SL+i]  = VW'(lo_v[k][i]);
                slot_hi[k*SL+i]  = VW'(hi_v[k][i]);
                slot_mod[k*SL+i] = MW'(tm[k][i]);
                slot_neg[k*SL+i] = tn[k][i][0];
            end
        end
    endtask

    function automatic int rd_pos(input int k, input int m);
        return int'($signed(dev_pos[k*NB+m]));
    endfunction
    function automatic int rd_neg(input int k, input int m);
        return int'($signed(dev_neg[k*NB+m]));
    endfunction

    task automatic run_case(input int kind);
        int lat;
        string ptag, ttag;
        make_case(kind);
        run_model();
        ptag = (e_dir != 0) ? "R5" : "R6";
        ttag = (e_reason == 8) ? "R8" : "R7";
        @(negedge clk);
        drive_case();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = SL + e_eval;
        // Cycle-by-cycle busy/done comparison (R3 fill length, R9 timing).
        for (int c = 0; c <= lat; c++) begin
            if (c > 0) @(negedge clk);
            chk(busy == (c < lat), "R9 busy", int'(busy), int'(c < lat));
            chk(done == (c == lat), $sformatf("R9/%s done timing", ttag), int'(done), int'(c == lat));
        end
        for (int k = 0; k < 3; k++) begin
            for (int m = 0; m < NB; m++) begin
                chk(rd_pos(k, m) == e_pos[k][m], $sformatf("R2 R3 %s %s pos k%0d m%0d", ptag, ttag, k, m), rd_pos(k, m), e_pos[k][m]);
                chk(rd_neg(k, m) == e_neg[k][m], $sformatf("R2 R3 %s %s neg k%0d m%0d", ptag, ttag, k, m), rd_neg(k, m), e_neg[k][m]);
                chk(rd_pos(k, m) >= 0 && rd_pos(k, m) <= amax[k][m], "R1 pos bound", rd_pos(k, m), amax[k][m]);
                chk(rd_neg(k, m) <= 0 && rd_neg(k, m) >= bmin[k][m], "R1 neg bound", rd_neg(k, m), bmin[k][m]);
            end
        end
        begin
            int ps[3];
            for (int k = 0; k < 3; k++) begin
                ps[k] = 0;
                for (int m = 0; m < NB; m++) ps[k] += rd_pos(k, m) + rd_neg(k, m);
            end
            chk(ps[0] - ps[1] == tgt[0] - tgt[1], "R4 phase 0-1", ps[0] - ps[1], tgt[0] - tgt[1]);
            chk(ps[1] - ps[2] == tgt[1] - tgt[2], "R4 phase 1-2", ps[1] - ps[2], tgt[1] - tgt[2]);
        end
        chk(err == 1'b0, "R10 err", int'(err), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chk(rd_pos(0, 0) == e_pos[0][0] && rd_neg(2, NB-1) == e_neg[2][NB-1], "R10 hold",
            rd_pos(0, 0), e_pos[0][0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R9 reset flags", int'({busy, done, err}), 0);
        chk(dev_pos == '0 && dev_neg == '0, "R9 reset outputs", 1, 0);
        run_case(1);
        run_case(2);
        run_case(3);
        run_case(2);
        for (int t = 0; t < 60; t++) run_case(t % 7 == 0 ? 3 : 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule